// File: doc/BRIEF.md
# Flag-Setting Logic and Arithmetic Unit

This block is the execute stage of a 32-bit datapath, reduced to its arithmetic core. Each cycle it takes an operation code, two operands, a flag-update request and a condition-pass qualifier. From these it produces a result word, a write-back enable for the destination register, and the condition flags that the operation leaves behind. The flags are negative, zero, carry and overflow, carried as a 4-bit vector in the order {N, Z, C, V}. A flag register inside the block captures that next value on every rising clock edge. The block reads its own stored carry, so a wide integer can be added or subtracted one word at a time, least significant word first.

The unit provides four bitwise operations, four adder operations (with and without the incoming carry), and three flag-only operations. The flag-only operations are compare, equality test and bit test. They never assert write-back, and the equality and bit tests leave carry and overflow alone. The condition-pass input stands for a predicate evaluated upstream. When it is low, the operation has no architectural effect.

Top module: `flag_alu`

## Requirements
- R1: Operation codes are AND=0, OR=1, XOR=2, NOT=3, ADD=4, ADC=5, SUB=6, SBC=7, CMP=8, TEQ=9 and TST=10. AND, OR and XOR give the bitwise function of A and B. NOT gives the inverse of B and ignores A. For example, 0x3C with 0x0F gives 0x0C, 0x3F and 0x33, and NOT of 0x3C gives 0xFFFFFFC3.
- R2: `result_we` is high only when `cond_pass` is high and the code is 0 to 7. It is low for codes 8 to 15.
- R3: The flags change only when `set_flags` and `cond_pass` are both high and the code is 0 to 10. Otherwise `flags_next` equals `flags_q`. `flags_q` loads `flags_next` on every clock edge.
- R4: Whenever the flags are updated, N is bit 31 of `result` and Z is set exactly when all 32 result bits are zero.
- R5: ADD gives A+B and ADC gives A+B+C, where C is the stored carry. The new C is the carry out of bit 31, and V is signed overflow.
- R6: SUB gives A-B and SBC gives A-B-(1-C). The new C is 1 when no borrow occurs, and V is signed overflow of the subtraction.
- R7: The bitwise operations (codes 0 to 3) update only N and Z. C and V keep their stored value.
- R8: CMP forms A-B, updates all four flags as SUB would, and never asserts write-back.
- R9: TEQ forms A XOR B and TST forms A AND B. Both update only N and Z and never assert write-back.
- R10: With `cond_pass` low, write-back is low and the flags hold, whatever the other inputs are.
- R11: A synchronous active-high `rst` clears `flags_q` to 0000.
- R12: A 64-bit sum is built word by word. ADD with flags on low words 0xF2100123 and 0x40023F51 gives 0x32124074 with C=1. ADC on high words 0x12A2E640 and 0x001019BF then gives 0x12B30000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_code | input | 4 | Operation code (see R1) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| set_flags | input | 1 | Request to update the flags |
| cond_pass | input | 1 | Condition qualifier; low suppresses all effects |
| result | output | 32 | Computed value (also driven for flag-only operations) |
| result_we | output | 1 | Write-back enable for the destination |
| flags_next | output | 4 | Flags {N,Z,C,V} after this operation |
| flags_q | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The only state is the 4-bit flag register. A wrong stored carry or overflow bit reaches the ports on the next edge through `flags_q`. It also shows in the same cycle on `result` of the next ADC or SBC, because both read the stored carry. A flag that is wrongly held or wrongly overwritten shows on `flags_next` combinationally in the cycle of the operation that misbehaves. It then persists in `flags_q` until the next updating operation. For this reason the carry-chain and keep-C/V sequences are run back to back, so that a corrupted bit is exposed within one or two cycles.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,
    OP_OR  = 4'd1,
    OP_XOR = 4'd2,
    OP_NOT = 4'd3,
    OP_ADD = 4'd4,
    OP_ADC = 4'd5,
    OP_SUB = 4'd6,
    OP_SBC = 4'd7,
    OP_CMP = 4'd8,
    OP_TEQ = 4'd9,
    OP_TST = 4'd10
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // Operations that deliver a value to the destination register.
  function automatic logic op_writes(input alu_op_e op);
    case (op)
      OP_AND, OP_OR, OP_XOR, OP_NOT,
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: op_writes = 1'b1;
      default:                        op_writes = 1'b0;
    endcase
  endfunction

  // Operations whose value comes from the adder; these also own C and V.
  function automatic logic op_uses_adder(input alu_op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: op_uses_adder = 1'b1;
      default:                                op_uses_adder = 1'b0;
    endcase
  endfunction

  // Every defined code may touch N and Z.
  function automatic logic op_known(input alu_op_e op);
    op_known = (op <= OP_TST);
  endfunction

endpackage

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res
);

  logic [W-1:0] and_v;
  logic [W-1:0] or_v;
  logic [W-1:0] xor_v;
  logic [W-1:0] not_v;

  // Per-bit gates kept as a repeated slice so each lane is a shallow cell.
  for (genvar i = 0; i < W; i++) begin : g_lane
    assign and_v[i] = a[i] & b[i];
    assign or_v[i]  = a[i] | b[i];
    assign xor_v[i] = a[i] ^ b[i];
    assign not_v[i] = ~b[i];
  end

  always_comb begin
    case (op)
      OP_AND, OP_TST: res = and_v;
      OP_OR:          res = or_v;
      OP_XOR, OP_TEQ: res = xor_v;
      OP_NOT:         res = not_v;
      default:        res = '0;
    endcase
  end

endmodule

// File: rtl/flag_alu_adder.sv
module flag_alu_adder
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           c_flag,
  output logic [W-1:0]   sum,
  output logic           carry_out,
  output logic           ovf
);

  localparam int SUM_W = W + 1;

  // Subtraction runs as A + ~B + carry-in.
  function automatic logic [W-1:0] second_operand(input alu_op_e o, input logic [W-1:0] v);
    case (o)
      OP_SUB, OP_SBC, OP_CMP: second_operand = ~v;
      default:                second_operand = v;
    endcase
  endfunction

  // The carry-in per operation; SBC reuses C as "no borrow".
  function automatic logic carry_in(input alu_op_e o, input logic c);
    case (o)
      OP_ADC, OP_SBC: carry_in = c;
      OP_SUB, OP_CMP: carry_in = 1'b1;
      default:        carry_in = 1'b0;
    endcase
  endfunction

  function automatic logic [SUM_W-1:0] wide_add(input logic [W-1:0] x,
                                                input logic [W-1:0] y,
                                                input logic         ci);
    wide_add = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  logic [W-1:0]     b_eff;
  logic             cin;
  logic [SUM_W-1:0] total;

  assign b_eff     = second_operand(op, b);
  assign cin       = carry_in(op, c_flag);
  assign total     = wide_add(a, b_eff, cin);
  assign sum       = total[W-1:0];
  assign carry_out = total[W];
  // Signed overflow: like-signed inputs giving an unlike-signed sum.
  assign ovf       = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

endmodule

// File: rtl/flag_alu_flags.sv
module flag_alu_flags
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   res,
  input  logic           carry_out,
  input  logic           ovf,
  input  logic           set_flags,
  input  logic           cond_pass,
  input  nzcv_t          flags_q,
  output logic           flag_update,
  output nzcv_t          flags_next
);

  nzcv_t calc;

  assign flag_update = set_flags && cond_pass && op_known(op);

  always_comb begin
    calc   = flags_q;
    calc.n = res[W-1];
    calc.z = ~|res;
    if (op_uses_adder(op)) begin
      calc.c = carry_out;
      calc.v = ovf;
    end
  end

  assign flags_next = flag_update ? calc : flags_q;

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         set_flags,
  input  logic         cond_pass,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic [3:0]   flags_next,
  output logic [3:0]   flags_q
);

  alu_op_e      op;
  logic [W-1:0] logic_res;
  logic [W-1:0] arith_res;
  logic         carry_out;
  logic         ovf;
  logic         flag_update;
  nzcv_t        flags_r;
  nzcv_t        flags_d;

  assign op = alu_op_e'(op_code);

  flag_alu_logic #(.W(W)) u_logic (
    .op  (op),
    .a   (opnd_a),
    .b   (opnd_b),
    .res (logic_res)
  );

  flag_alu_adder #(.W(W)) u_adder (
    .op        (op),
    .a         (opnd_a),
    .b         (opnd_b),
    .c_flag    (flags_r.c),
    .sum       (arith_res),
    .carry_out (carry_out),
    .ovf       (ovf)
  );

  assign result    = op_uses_adder(op) ? arith_res : logic_res;
  assign result_we = cond_pass && op_writes(op);

  flag_alu_flags #(.W(W)) u_flags (
    .op          (op),
    .res         (result),
    .carry_out   (carry_out),
    .ovf         (ovf),
    .set_flags   (set_flags),
    .cond_pass   (cond_pass),
    .flags_q     (flags_r),
    .flag_update (flag_update),
    .flags_next  (flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) flags_r <= '0;
    else     flags_r <= flags_d;
  end

  assign flags_next = flags_d;
  assign flags_q    = flags_r;

endmodule

// File: rtl/flag_alu_checker.sv
module flag_alu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op_code,
  input logic         set_flags,
  input logic         cond_pass,
  input logic [W-1:0] result,
  input logic         result_we,
  input logic [3:0]   flags_next,
  input logic [3:0]   flags_q,
  input logic         flag_update
);

  // R10
  no_write_on_fail_chk: assert property (@(posedge clk) disable iff (rst)
    !cond_pass |-> !result_we);

  // R2
  writer_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_pass && op_code <= 4'd7) |-> result_we);

  // R8
  flag_only_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (op_code >= 4'd8) |-> !result_we);

  // R3
  hold_without_update_chk: assert property (@(posedge clk) disable iff (rst)
    !(set_flags && cond_pass) |-> (flags_next == flags_q));

  // R3
  flag_load_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flags_q == $past(flags_next)));

  // R4
  nz_match_chk: assert property (@(posedge clk) disable iff (rst)
    flag_update |-> (flags_next[3] == result[W-1] && flags_next[2] == (result == '0)));

  // R7
  logic_keeps_cv_chk: assert property (@(posedge clk) disable iff (rst)
    (op_code <= 4'd3) |-> (flags_next[1:0] == flags_q[1:0]));

  // R9
  test_keeps_cv_chk: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd9 || op_code == 4'd10) |-> (flags_next[1:0] == flags_q[1:0]));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flags_q == 4'b0000));

endmodule

bind flag_alu flag_alu_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_code     (op_code),
  .set_flags   (set_flags),
  .cond_pass   (cond_pass),
  .result      (result),
  .result_we   (result_we),
  .flags_next  (flags_next),
  .flags_q     (flags_q),
  .flag_update (flag_update)
);

// File: tb/tb_flag_alu.sv
`timescale 1ns/1ps
module tb_flag_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_code = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        set_flags = 1'b0;
  logic        cond_pass = 1'b0;
  logic [31:0] result;
  logic        result_we;
  logic [3:0]  flags_next;
  logic [3:0]  flags_q;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [3:0]  exp_flags = '0;
  logic [31:0] last_res;
  logic [3:0]  last_next;

  always #2.5 clk = ~clk;

  flag_alu dut (
    .clk(clk), .rst(rst), .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .set_flags(set_flags), .cond_pass(cond_pass), .result(result),
    .result_we(result_we), .flags_next(flags_next), .flags_q(flags_q)
  );

  // {op, a, b, set_flags, cond_pass}
  localparam int NV = 17;
  localparam logic [69:0] VECS [NV] = '{
    {4'd4,  32'h7FFFFFFF, 32'h00000001, 1'b1, 1'b1},
    {4'd4,  32'hFFFFFFFF, 32'h00000001, 1'b1, 1'b1},
    {4'd5,  32'h00000005, 32'h00000003, 1'b1, 1'b1},
    {4'd6,  32'h00000005, 32'h00000005, 1'b1, 1'b1},
    {4'd6,  32'h00000003, 32'h00000005, 1'b1, 1'b1},
    {4'd7,  32'h00000010, 32'h00000003, 1'b1, 1'b1},
    {4'd8,  32'h80000000, 32'h00000001, 1'b1, 1'b1},
    {4'd9,  32'hAAAA5555, 32'hAAAA5555, 1'b1, 1'b1},
    {4'd10, 32'hF0F0F0F0, 32'h0F0F0F0F, 1'b1, 1'b1},
    {4'd0,  32'hFFFF0000, 32'h80008000, 1'b1, 1'b1},
    {4'd1,  32'h00000000, 32'h00000000, 1'b1, 1'b1},
    {4'd2,  32'h12345678, 32'hFFFFFFFF, 1'b0, 1'b1},
    {4'd3,  32'h5A5A5A5A, 32'h00000000, 1'b1, 1'b1},
    {4'd4,  32'h00000001, 32'h00000002, 1'b1, 1'b0},
    {4'd7,  32'h00000100, 32'h00000001, 1'b1, 1'b1},
    {4'd8,  32'h00000001, 32'h00000002, 1'b0, 1'b1},
    {4'd15, 32'h00000001, 32'h00000002, 1'b1, 1'b1}
  };

  function automatic string tag_of(input logic [3:0] op);
    if (op <= 4'd3)       return "R1";
    else if (op <= 4'd5)  return "R5";
    else if (op <= 4'd7)  return "R6";
    else if (op == 4'd8)  return "R8";
    else if (op <= 4'd10) return "R9";
    return "R2";
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirement text.
  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic sf, input logic cp, input logic [3:0] fin,
                       output logic [31:0] r, output logic we, output logic [3:0] fout);
    logic [63:0] big;
    longint sv;
    logic cc, vv, touch_cv, bw;
    cc = fin[1]; vv = fin[0]; touch_cv = 1'b0; r = '0;
    case (op)
      4'd0, 4'd10: r = a & b;
      4'd1:        r = a | b;
      4'd2, 4'd9:  r = a ^ b;
      4'd3:        r = ~b;
      4'd4, 4'd5: begin
        bw  = (op == 4'd5) ? fin[1] : 1'b0;
        big = {32'b0, a} + {32'b0, b} + {63'b0, bw};
        r   = big[31:0];
        cc  = big[32];
        sv  = longint'($signed(a)) + longint'($signed(b)) + longint'(bw);
        vv  = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
        touch_cv = 1'b1;
      end
      4'd6, 4'd7, 4'd8: begin
        bw  = (op == 4'd7) ? !fin[1] : 1'b0;
        r   = a - b - {31'b0, bw};
        cc  = ({32'b0, a} >= ({32'b0, b} + {63'b0, bw}));
        sv  = longint'($signed(a)) - longint'($signed(b)) - longint'(bw);
        vv  = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
        touch_cv = 1'b1;
      end
      default: r = '0;
    endcase
    we = cp && (op <= 4'd7);
    fout = fin;
    if (sf && cp && op <= 4'd10) begin
      fout[3] = r[31];
      fout[2] = (r == 32'h0);
      if (touch_cv) fout[1:0] = {cc, vv};
    end
  endtask

  task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic sf, input logic cp);
    logic [31:0] er; logic ew; logic [3:0] ef;
    string tg;
    tg = tag_of(op);
    model(op, a, b, sf, cp, exp_flags, er, ew, ef);
    op_code = op; opnd_a = a; opnd_b = b; set_flags = sf; cond_pass = cp;
    #1;
    last_res = result; last_next = flags_next;
    if (op <= 4'd10) check(result == er, tg, result, er);
    check(result_we == ew, "R2", {31'b0, result_we}, {31'b0, ew});
    check(flags_next == ef, (sf && cp) ? "R4" : "R3", {28'b0, flags_next}, {28'b0, ef});
    @(posedge clk); #1;
    check(flags_q == ef, "R3", {28'b0, flags_q}, {28'b0, ef});
    exp_flags = ef;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    // R11 reset state
    check(flags_q == 4'b0000, "R11", {28'b0, flags_q}, 32'h0);
    exp_flags = '0;

    for (int i = 0; i < NV; i++)
      run(VECS[i][69:66], VECS[i][65:34], VECS[i][33:2], VECS[i][1], VECS[i][0]);

    // R1 bitwise examples on 0x3C / 0x0F
    run(4'd0, 32'h3C, 32'h0F, 1'b0, 1'b1);
    check(last_res == 32'h0C, "R1", last_res, 32'h0C);
    run(4'd1, 32'h3C, 32'h0F, 1'b0, 1'b1);
    check(last_res == 32'h3F, "R1", last_res, 32'h3F);
    run(4'd2, 32'h3C, 32'h0F, 1'b0, 1'b1);
    check(last_res == 32'h33, "R1", last_res, 32'h33);
    run(4'd3, 32'hDEAD0000, 32'h3C, 1'b0, 1'b1);
    check(last_res == 32'hFFFFFFC3, "R1", last_res, 32'hFFFFFFC3);

    // R7 logic op keeps C and V: first make C=1,V=1 (0x80000000 + 0x80000000)
    run(4'd4, 32'h80000000, 32'h80000000, 1'b1, 1'b1);
    check(flags_q[1:0] == 2'b11, "R5", {30'b0, flags_q[1:0]}, 32'h3);
    run(4'd0, 32'hFFFFFFFF, 32'h80000001, 1'b1, 1'b1);
    check(last_next == 4'b1011, "R7", {28'b0, last_next}, 32'hB);

    // R10 suppressed SUB with set_flags: flags and write-back untouched
    run(4'd6, 32'h0, 32'h1, 1'b1, 1'b0);
    check(flags_q == 4'b1011, "R10", {28'b0, flags_q}, 32'hB);

    // R12 64-bit add, low words then high words with carry
    run(4'd4, 32'hF2100123, 32'h40023F51, 1'b1, 1'b1);
    check(last_res == 32'h32124074, "R12", last_res, 32'h32124074);
    check(flags_q[1] == 1'b1, "R12", {31'b0, flags_q[1]}, 32'h1);
    run(4'd5, 32'h12A2E640, 32'h001019BF, 1'b0, 1'b1);
    check(last_res == 32'h12B30000, "R12", last_res, 32'h12B30000);

    // R6 SBC with C=1 behaves as plain subtract: 9 - 4 = 5
    run(4'd7, 32'h9, 32'h4, 1'b1, 1'b1);
    check(last_res == 32'h5, "R6", last_res, 32'h5);

    // R11 mid-run reset with flags non-zero
    run(4'd8, 32'h0, 32'h1, 1'b1, 1'b1);
    rst = 1'b1; cond_pass = 1'b0;
    @(posedge clk); #1;
    check(flags_q == 4'b0000, "R11", {28'b0, flags_q}, 32'h0);
    rst = 1'b0; exp_flags = '0;
    run(4'd1, 32'h0, 32'h0, 1'b0, 1'b1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule